// File: doc/BRIEF.md
# Shared-Adder Arithmetic Logic Unit

A purely combinational arithmetic logic unit of configurable width in which every operation, arithmetic or logical, comes out of the sum bits of one ripple-carry adder. Per bit, an X multiplexer and a Y multiplexer condition the two adder inputs from the operands. The sum of those conditioned inputs is either an arithmetic result or a bitwise Boolean function of the operands. No separate gate array or result multiplexer produces the logic results.

A mode input picks arithmetic or logic. A two-bit function select and a carry input pick the operation inside that mode. In logic mode the carry chain is held at zero at every position. This keeps the conditioned operands from producing ripple carries that would corrupt neighbouring bits. The block is meant to sit in a datapath that registers its inputs and outputs elsewhere.

Top module: `shared_adder_alu`

## Requirements
- R1: With `logic_mode`=0 and `fsel`=2'b00, `result` is `opa`+`carry_in` modulo 2^WIDTH and `carry_out` is the carry out of that sum. Concretely, `carry_in`=0 passes `opa` with `carry_out`=0, and `carry_in`=1 increments `opa`.
- R2: With `logic_mode`=0 and `fsel`=2'b01, {`carry_out`,`result`} equals `opa`+`opb`+`carry_in`.
- R3: With `logic_mode`=0 and `fsel`=2'b10, {`carry_out`,`result`} equals `opa`+(~`opb`)+`carry_in`. With `carry_in`=1 this gives `opa`−`opb` in two's complement, and `carry_out`=1 exactly when `opa`>=`opb` unsigned.
- R4: With `logic_mode`=0 and `fsel`=2'b11, {`carry_out`,`result`} equals `opa`+(all ones)+`carry_in`. With `carry_in`=0 this gives `opa`−1, with `carry_out`=0 only when `opa` is zero. With `carry_in`=1 it passes `opa` with `carry_out`=1.
- R5: With `logic_mode`=1 and `fsel`=2'b00, `result` is `opa` OR `opb`.
- R6: With `logic_mode`=1 and `fsel`=2'b01, `result` is `opa` AND `opb`, including when every bit of both operands is 1.
- R7: With `logic_mode`=1 and `fsel`=2'b10, `result` is `opa` XOR `opb`.
- R8: With `logic_mode`=1 and `fsel`=2'b11, `result` is NOT `opa`, and `opb` is ignored.
- R9: With `logic_mode`=1, `carry_out` is 0 and `carry_in` has no effect on `result`.
- R10: R1 to R9 hold for any WIDTH, including 1 and 4 as well as the default of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| logic_mode | input | 1 | 0 = arithmetic, 1 = logic |
| fsel | input | 2 | Function select within the mode |
| carry_in | input | 1 | Carry into bit 0 (arithmetic mode only) |
| result | output | WIDTH | Adder sum, i.e. the operation result |
| carry_out | output | 1 | Final carry in arithmetic mode, 0 in logic mode |

## Verification
A hand-worked table drives the default width with operands chosen so that each one separates two close variants. All-ones operands for AND expose a live carry chain in logic mode. Equal operands for addition produce a carry out of the top bit. Subtraction with the smaller operand first and second separates borrow from no borrow. A zero operand in decrement checks the missing carry. An exhaustive sweep of all operand pairs and all sixteen control combinations at widths 4 and 1 then catches any slice- or edge-dependent precoding error, and random vectors at width 8 cover the long carry paths against an independent golden model.

// File: rtl/sa_alu_pkg.sv
package sa_alu_pkg;
  // function select encodings; meaning depends on the mode bit
  typedef enum logic [1:0] {
    FN_PASS_OR  = 2'b00,  // arith: A + Cin        logic: A | B
    FN_ADD_AND  = 2'b01,  // arith: A + B + Cin    logic: A & B
    FN_SUBC_XOR = 2'b10,  // arith: A + ~B + Cin   logic: A ^ B
    FN_ONES_NOT = 2'b11   // arith: A + 1s + Cin   logic: ~A
  } fsel_e;

  typedef struct packed {
    logic x;
    logic y;
  } operand_pair_t;
endpackage

// File: rtl/sa_operand_slice.sv
module sa_operand_slice
  import sa_alu_pkg::*;
(
  input  logic          a_bit,
  input  logic          b_bit,
  input  logic          logic_mode,
  input  logic [1:0]    fsel,
  output operand_pair_t xy
);
  always_comb begin
    xy.x = a_bit;
    xy.y = 1'b0;
    if (!logic_mode) begin
      xy.x = a_bit;
      unique case (fsel_e'(fsel))
        FN_PASS_OR:  xy.y = 1'b0;
        FN_ADD_AND:  xy.y = b_bit;
        FN_SUBC_XOR: xy.y = ~b_bit;
        FN_ONES_NOT: xy.y = 1'b1;
        default:     xy.y = 1'b0;
      endcase
    end else begin
      unique case (fsel_e'(fsel))
        FN_PASS_OR: begin
          xy.x = a_bit | b_bit;
          xy.y = 1'b0;
        end
        FN_ADD_AND: begin
          xy.x = ~a_bit & b_bit;
          xy.y = b_bit;
        end
        FN_SUBC_XOR: begin
          xy.x = ~a_bit;
          xy.y = ~b_bit;
        end
        FN_ONES_NOT: begin
          xy.x = a_bit;
          xy.y = 1'b1;
        end
        default: begin
          xy.x = a_bit;
          xy.y = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sa_operand_prep.sv
module sa_operand_prep
  import sa_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             logic_mode,
  input  logic [1:0]       fsel,
  output logic [WIDTH-1:0] x_vec,
  output logic [WIDTH-1:0] y_vec
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    operand_pair_t pair;
    sa_operand_slice u_slice (
      .a_bit      (opa[i]),
      .b_bit      (opb[i]),
      .logic_mode (logic_mode),
      .fsel       (fsel),
      .xy         (pair)
    );
    assign x_vec[i] = pair.x;
    assign y_vec[i] = pair.y;
  end
endmodule

// File: rtl/sa_ripple_adder.sv
module sa_ripple_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_vec,
  input  logic [WIDTH-1:0] y_vec,
  input  logic             cin,
  input  logic             kill_carry,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int CHAIN = WIDTH + 1;

  logic [CHAIN-1:0] chain;

  assign chain[0] = cin & ~kill_carry;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    logic prop;
    logic gen;
    assign prop         = x_vec[i] ^ y_vec[i];
    assign gen          = x_vec[i] & y_vec[i];
    assign sum[i]       = prop ^ chain[i];
    assign chain[i+1]   = (gen | (prop & chain[i])) & ~kill_carry;
  end

  assign cout = chain[CHAIN-1];
endmodule

// File: rtl/shared_adder_alu.sv
module shared_adder_alu #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             logic_mode,
  input  logic [1:0]       fsel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  logic [WIDTH-1:0] x_vec;
  logic [WIDTH-1:0] y_vec;

  sa_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .opa        (opa),
    .opb        (opb),
    .logic_mode (logic_mode),
    .fsel       (fsel),
    .x_vec      (x_vec),
    .y_vec      (y_vec)
  );

  // logic mode zeroes every carry so each sum bit is x ^ y alone
  sa_ripple_adder #(.WIDTH(WIDTH)) u_add (
    .x_vec      (x_vec),
    .y_vec      (y_vec),
    .cin        (carry_in),
    .kill_carry (logic_mode),
    .sum        (result),
    .cout       (carry_out)
  );
endmodule

// File: rtl/sa_alu_chk.sv
module sa_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             logic_mode,
  input logic [1:0]       fsel,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  logic [WIDTH:0] add_ref;
  logic [WIDTH:0] inc_ref;
  assign add_ref = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in};
  assign inc_ref = {1'b0, opa} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    if (logic_mode) begin
      p_logic_cout_zero_r9: assert (carry_out == 1'b0)
        else $error("carry_out set in logic mode");
    end
    if (!logic_mode && fsel == 2'b00) begin
      p_pass_inc_r1: assert ({carry_out, result} == inc_ref)
        else $error("pass/increment mismatch");
    end
    if (!logic_mode && fsel == 2'b01) begin
      p_add_r2: assert ({carry_out, result} == add_ref)
        else $error("add mismatch");
    end
    if (logic_mode && fsel == 2'b00) begin
      p_or_r5: assert (result == (opa | opb)) else $error("OR mismatch");
    end
    if (logic_mode && fsel == 2'b01) begin
      p_and_r6: assert (result == (opa & opb)) else $error("AND mismatch");
    end
    if (logic_mode && fsel == 2'b10) begin
      p_xor_r7: assert (result == (opa ^ opb)) else $error("XOR mismatch");
    end
    if (logic_mode && fsel == 2'b11) begin
      p_not_r8: assert (result == ~opa) else $error("NOT mismatch");
    end
  end
endmodule

bind shared_adder_alu sa_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opa        (opa),
  .opb        (opb),
  .logic_mode (logic_mode),
  .fsel       (fsel),
  .carry_in   (carry_in),
  .result     (result),
  .carry_out  (carry_out)
);

// File: tb/tb_shared_adder_alu.sv
module tb_shared_adder_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // width-8 instance (default)
  logic [7:0] a8, b8, r8;
  logic       c8;
  // width-4 instance
  logic [3:0] a4, b4, r4;
  logic       c4;
  // width-1 instance
  logic [0:0] a1, b1, r1;
  logic       c1;
  logic       mode;
  logic [1:0] sel;
  logic       cin;

  shared_adder_alu dut (
    .opa(a8), .opb(b8), .logic_mode(mode), .fsel(sel), .carry_in(cin),
    .result(r8), .carry_out(c8));
  shared_adder_alu #(.WIDTH(4)) dut_w4 (
    .opa(a4), .opb(b4), .logic_mode(mode), .fsel(sel), .carry_in(cin),
    .result(r4), .carry_out(c4));
  shared_adder_alu #(.WIDTH(1)) dut_w1 (
    .opa(a1), .opb(b1), .logic_mode(mode), .fsel(sel), .carry_in(cin),
    .result(r1), .carry_out(c1));

  // golden model from the requirements; returns {cout, result}
  function automatic logic [16:0] golden(input int w, input logic m,
                                         input logic [1:0] s, input logic c,
                                         input logic [15:0] a, input logic [15:0] b);
    logic [16:0] mask, sum, ya;
    logic [15:0] res;
    mask = (17'd1 << w) - 17'd1;
    if (!m) begin
      case (s)
        2'b00:   ya = 17'd0;
        2'b01:   ya = {1'b0, b};
        2'b10:   ya = {1'b0, ~b} & mask;
        default: ya = mask;
      endcase
      sum = ({1'b0, a} & mask) + ya + {16'd0, c};
      res = sum[15:0] & mask[15:0];
      return {sum[w], res};
    end
    case (s)
      2'b00:   res = a | b;
      2'b01:   res = a & b;
      2'b10:   res = a ^ b;
      default: res = ~a;
    endcase
    return {1'b0, res & mask[15:0]};
  endfunction

  function automatic string tag_of(input logic m, input logic [1:0] s, input logic c);
    if (m && c) return "R9";
    if (!m) case (s) 2'b00: return "R1"; 2'b01: return "R2"; 2'b10: return "R3"; default: return "R4"; endcase
    case (s) 2'b00: return "R5"; 2'b01: return "R6"; 2'b10: return "R7"; default: return "R8"; endcase
  endfunction

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual cout=%0b res=%h expected cout=%0b res=%h",
               tag, act[16], act[15:0], exp[16], exp[15:0]);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b,
                       input logic m, input logic [1:0] s, input logic c);
    @(posedge clk);
    a8 <= a; b8 <= b; a4 <= a[3:0]; b4 <= b[3:0]; a1 <= a[0]; b1 <= b[0];
    mode <= m; sel <= s; cin <= c;
    @(negedge clk);
  endtask

  // a, b, mode, sel, cin, expected result, expected cout
  localparam logic [28:0] TBL [16] = '{
    {8'hFF, 8'h00, 1'b0, 2'b00, 1'b1, 8'h00, 1'b1},  // R1 increment wraps
    {8'h3C, 8'h00, 1'b0, 2'b00, 1'b0, 8'h3C, 1'b0},  // R1 transfer
    {8'h80, 8'h80, 1'b0, 2'b01, 1'b0, 8'h00, 1'b1},  // R2 carry out
    {8'h12, 8'h34, 1'b0, 2'b01, 1'b1, 8'h47, 1'b0},  // R2 plus one
    {8'h50, 8'h30, 1'b0, 2'b10, 1'b1, 8'h20, 1'b1},  // R3 no borrow
    {8'h30, 8'h50, 1'b0, 2'b10, 1'b1, 8'hE0, 1'b0},  // R3 borrow
    {8'h30, 8'h50, 1'b0, 2'b10, 1'b0, 8'hDF, 1'b0},  // R3 ones complement
    {8'h00, 8'h00, 1'b0, 2'b11, 1'b0, 8'hFF, 1'b0},  // R4 decrement zero
    {8'h01, 8'h77, 1'b0, 2'b11, 1'b0, 8'h00, 1'b1},  // R4 decrement one
    {8'hA5, 8'h00, 1'b0, 2'b11, 1'b1, 8'hA5, 1'b1},  // R4 transfer
    {8'hF0, 8'h0F, 1'b1, 2'b00, 1'b1, 8'hFF, 1'b0},  // R5 OR
    {8'hCC, 8'hAA, 1'b1, 2'b01, 1'b0, 8'h88, 1'b0},  // R6 AND
    {8'hCC, 8'hAA, 1'b1, 2'b10, 1'b0, 8'h66, 1'b0},  // R7 XOR
    {8'hC3, 8'h5A, 1'b1, 2'b11, 1'b0, 8'h3C, 1'b0},  // R8 NOT
    {8'hFF, 8'hFF, 1'b1, 2'b01, 1'b1, 8'hFF, 1'b0},  // R6 R9 all-ones AND
    {8'h00, 8'hFF, 1'b1, 2'b11, 1'b1, 8'hFF, 1'b0}   // R8 R9 NOT ignores B
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    a8 = '0; b8 = '0; a4 = '0; b4 = '0; a1 = '0; b1 = '0;
    mode = 1'b0; sel = 2'b00; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", {c8, 8'h00, r8}, 17'd0);

    // directed table
    for (int i = 0; i < 16; i++) begin
      logic [28:0] v;
      v = TBL[i];
      apply(v[28:21], v[20:13], v[12], v[11:10], v[9]);
      check(tag_of(v[12], v[11:10], v[9]), {c8, 8'h00, r8}, {v[0], 8'h00, v[8:1]});
    end

    // R9: carry_in toggled in logic mode leaves result unchanged
    for (int s = 0; s < 4; s++) begin
      logic [7:0] first;
      apply(8'hB7, 8'h6D, 1'b1, s[1:0], 1'b0);
      first = r8;
      apply(8'hB7, 8'h6D, 1'b1, s[1:0], 1'b1);
      check("R9 cin ignored", {c8, 8'h00, r8}, {1'b0, 8'h00, first});
    end

    // exhaustive widths 4 and 1 (R10), all control combinations
    for (int ctl = 0; ctl < 16; ctl++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic m, c;
          logic [1:0] s;
          m = ctl[3]; s = ctl[2:1]; c = ctl[0];
          apply(8'(a), 8'(b), m, s, c);
          check("R10 w4", {c4, 12'h000, r4},
                golden(4, m, s, c, 16'(a), 16'(b)));
          if (a < 2 && b < 2)
            check("R10 w1", {c1, 15'h0000, r1},
                  golden(1, m, s, c, 16'(a), 16'(b)));
        end
      end
    end

    // random width 8
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] a, b;
      logic [3:0] ctl;
      a = 8'($urandom); b = 8'($urandom); ctl = 4'($urandom);
      apply(a, b, ctl[3], ctl[2:1], ctl[0]);
      check(tag_of(ctl[3], ctl[2:1], ctl[0]), {c8, 8'h00, r8},
            golden(8, ctl[3], ctl[2:1], ctl[0], {8'h00, a}, {8'h00, b}));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule